// File: doc/BRIEF.md
# Bipolar DAC Setpoint Packet Encoder

This block turns a request to set one of four analog output channels into the word a serial output stage transmits to a pair of dual-channel DACs. Each request carries a channel number from 0 to 3 and a signed 16-bit setpoint. The DACs take an unsigned magnitude. The sign goes to a separate 4-bit polarity image, one bit per channel, which the output stage must apply before the first serial bit leaves. The encoder produces the magnitude, updates the polarity image and limits the magnitude to 13 bits. It then builds a 32-bit packet and a four-slot chip-select plan that tells the shifter which device each byte is for.

Only two of the four packet bytes carry real data, and they go to the selected DAC. The other two are filler. They are sent to the trim device so that the serial clock keeps running past the end of the real data, which avoids a clock glitch on the DAC. All outputs are registered. Every accepted request produces a one-cycle valid pulse on the cycle after it is presented. The polarity image is updated on that same edge, so it is ready before the packet is handed to the shifter.

Top module: `dac_setpoint_encoder`

## Requirements
- R1: A negative setpoint produces a magnitude equal to its negation and sets polarity bit [channel] to 1.
- R2: A setpoint of zero or above clears polarity bit [channel]. The other three polarity bits keep their values on every request.
- R3: A magnitude above 0x1FFF is sent as 0x1FFF. Smaller magnitudes are sent unchanged in packet bits [12:0].
- R4: The setpoint -32768 is treated as magnitude 32768 and is therefore sent as 0x1FFF, with the polarity bit set.
- R5: Packet bits [31:24] equal 0x0F, bits [23:16] equal 0, bit 15 equals channel bit 0, bit 14 equals 1 and bit 13 equals 0.
- R6: The plan is four 2-bit codes sent in transmit order, with slot k in out_cs_plan[2k+1:2k]. Slot 0 carries packet byte 1 and slot 1 carries packet byte 0. Both go to the selected DAC: code 1 when channel bit 1 is 1, and code 2 otherwise.
- R7: Slot 2 carries packet byte 3 and slot 3 carries packet byte 2. Both use code 3, the trim device select.
- R8: out_valid is high for exactly the cycle after each cycle with req_valid high. When req_valid is low, out_valid is low on the next cycle and out_packet, out_cs_plan and out_polarity keep their values.
- R9: While rst is high, out_valid, out_packet, out_cs_plan and out_polarity are all zero on the next cycle.
- R10: out_polarity already holds the bit updated by a request in the same cycle that out_valid presents that request's packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_chan | input | 2 | Target channel |
| req_setpoint | input | 16 | Signed two's-complement setpoint |
| out_valid | output | 1 | One-cycle pulse per accepted request |
| out_packet | output | 32 | Packet word for the serial stage |
| out_cs_plan | output | 8 | Chip-select code per transmit slot |
| out_polarity | output | 4 | Polarity image, one bit per channel |

## Verification
Each result is due exactly one clock after its request: valid, packet, plan and polarity bit. An idle cycle must leave everything as it was on the following clock. The bench holds a behavioural model that moves forward one step per clock. It compares all four outputs at each falling edge, a half period after the edge that updated them, and only then drives the next request. The stimulus covers boundary setpoints (0, ±0x1FFF, 0x2000, 32767, -32768), every channel, and idle gaps mixed with a long pseudo-random run.

// File: rtl/dacenc_pkg.sv
package dacenc_pkg;
    localparam int SP_W     = 16;
    localparam int MAG_W    = 13;
    localparam int CH_N     = 4;
    localparam int CH_W     = $clog2(CH_N);
    localparam int PKT_W    = 32;
    localparam int SLOTS    = 4;
    localparam int CS_W     = 2;
    localparam int PLAN_W   = SLOTS * CS_W;
    localparam int WIDE_W   = SP_W + 1;
    localparam logic [MAG_W-1:0] MAG_MAX = {MAG_W{1'b1}};
    localparam logic [PKT_W-1:0] PKT_FIXED = 32'h0F00_4000;
    localparam int ADDR_BIT = 15;

    typedef enum logic [CS_W-1:0] {
        CS_IDLE = 2'd0,
        CS_SEL1 = 2'd1,
        CS_SEL2 = 2'd2,
        CS_TRIM = 2'd3
    } cs_code_e;

    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
    } signmag_t;

    function automatic signmag_t to_signmag(input logic [SP_W-1:0] sp);
        signmag_t r;
        logic [WIDE_W-1:0] wide;
        wide  = {sp[SP_W-1], sp};
        r.neg = sp[SP_W-1];
        if (r.neg) wide = -wide;
        if (wide > WIDE_W'(MAG_MAX)) r.mag = MAG_MAX;
        else                         r.mag = wide[MAG_W-1:0];
        return r;
    endfunction
endpackage

// File: rtl/dacenc_magnitude.sv
module dacenc_magnitude
    import dacenc_pkg::*;
(
    input  logic [SP_W-1:0] setpoint,
    output signmag_t        sm
);
    always_comb sm = to_signmag(setpoint);
endmodule

// File: rtl/dacenc_polarity.sv
module dacenc_polarity
    import dacenc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            upd,
    input  logic [CH_W-1:0] chan,
    input  logic            neg,
    output logic [CH_N-1:0] image
);
    always_ff @(posedge clk) begin
        if (rst)      image <= '0;
        else if (upd) image[chan] <= neg;
    end

    // R1
    pol_bit_follows_sign_chk: assert property (@(posedge clk) disable iff (rst)
        upd |=> image[$past(chan)] == $past(neg));
    // R2
    pol_others_kept_chk: assert property (@(posedge clk) disable iff (rst)
        upd |=> ((image ^ $past(image)) & ~(CH_N'(1) << $past(chan))) == '0);
endmodule

// File: rtl/dacenc_packer.sv
module dacenc_packer
    import dacenc_pkg::*;
(
    input  logic [CH_W-1:0]   chan,
    input  logic [MAG_W-1:0]  mag,
    output logic [PKT_W-1:0]  packet,
    output logic [PLAN_W-1:0] plan
);
    cs_code_e dev_cs;

    always_comb begin
        dev_cs = chan[1] ? CS_SEL1 : CS_SEL2;
        packet = PKT_FIXED;
        packet[ADDR_BIT] = chan[0];
        packet[MAG_W-1:0] = mag;
    end

    // slots 0,1 carry the data bytes, slots 2,3 the filler for the trim device
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        if (k < SLOTS / 2) begin : g_dac
            assign plan[k*CS_W +: CS_W] = dev_cs;
        end else begin : g_trim
            assign plan[k*CS_W +: CS_W] = CS_TRIM;
        end
    end
endmodule

// File: rtl/dac_setpoint_encoder.sv
module dac_setpoint_encoder
    import dacenc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_chan,
    input  logic [15:0]       req_setpoint,
    output logic              out_valid,
    output logic [31:0]       out_packet,
    output logic [7:0]        out_cs_plan,
    output logic [3:0]        out_polarity
);
    signmag_t          sm;
    logic [PKT_W-1:0]  pkt_next;
    logic [PLAN_W-1:0] plan_next;

    dacenc_magnitude u_mag (
        .setpoint (req_setpoint),
        .sm       (sm)
    );

    dacenc_polarity u_pol (
        .clk   (clk),
        .rst   (rst),
        .upd   (req_valid),
        .chan  (req_chan),
        .neg   (sm.neg),
        .image (out_polarity)
    );

    dacenc_packer u_pack (
        .chan   (req_chan),
        .mag    (sm.mag),
        .packet (pkt_next),
        .plan   (plan_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_packet  <= '0;
            out_cs_plan <= '0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                out_packet  <= pkt_next;
                out_cs_plan <= plan_next;
            end
        end
    end

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(req_valid));
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(out_packet) && $stable(out_cs_plan) && $stable(out_polarity));
    // R5
    fixed_fields_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_packet[31:13] == {8'h0F, 8'h00, $past(req_chan[0]), 2'b10});
    // R6
    dev_select_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_cs_plan[3:0] == ($past(req_chan[1]) ? 4'b0101 : 4'b1010));
    // R10
    pol_with_packet_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_polarity[$past(req_chan)] == $past(req_setpoint[15]));
endmodule

// File: tb/sim_dac_setpoint_encoder.sv
module sim_dac_setpoint_encoder;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [1:0]  req_chan;
    logic [15:0] req_setpoint;
    logic        out_valid;
    logic [31:0] out_packet;
    logic [7:0]  out_cs_plan;
    logic [3:0]  out_polarity;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic        e_valid = 0;
    logic [31:0] e_pkt   = 0;
    logic [7:0]  e_plan  = 0;
    logic [3:0]  e_pol   = 0;
    string       tag_pkt = "R8", tag_pol = "R8";
    int unsigned seed    = 32'h1234_5678;

    always #10 clk = ~clk;

    dac_setpoint_encoder u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_chan(req_chan),
        .req_setpoint(req_setpoint), .out_valid(out_valid), .out_packet(out_packet),
        .out_cs_plan(out_cs_plan), .out_polarity(out_polarity)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("R8", "out_valid", 32'(out_valid), 32'(e_valid));
        chk(tag_pkt, "out_packet", out_packet, e_pkt);
        chk("R6 R7", "out_cs_plan", 32'(out_cs_plan), 32'(e_plan));
        chk(tag_pol, "out_polarity", 32'(out_polarity), 32'(e_pol));
    endtask

    task automatic step(input bit v, input int ch, input int sp);
        int mag;
        int sel;
        @(negedge clk);
        compare();
        req_valid    = v;
        req_chan     = ch[1:0];
        req_setpoint = sp[15:0];
        e_valid = v;
        tag_pol = "R8";
        tag_pkt = "R8";
        if (v) begin
            sp  = $signed(sp[15:0]);
            mag = (sp < 0) ? -sp : sp;
            if (sp == -32768)   tag_pkt = "R4";
            else if (mag > 8191) tag_pkt = "R3";
            else if (sp < 0)    tag_pkt = "R1";
            else                tag_pkt = "R5";
            if (mag > 8191) mag = 8191;
            e_pkt = 32'h0F00_4000 | (32'(ch & 1) << 15) | 32'(mag);
            sel = ch[1] ? 1 : 2;
            e_plan = {2'd3, 2'd3, sel[1:0], sel[1:0]};
            e_pol[ch] = (sp < 0);
            tag_pol = (sp < 0) ? "R1 R10" : "R2 R10";
        end
    endtask

    function automatic int unsigned nxt(input int unsigned s);
        s ^= s << 13; s ^= s >> 17; s ^= s << 5;
        return s;
    endfunction

    initial begin
        rst = 1; req_valid = 0; req_chan = 0; req_setpoint = 0;
        repeat (3) @(negedge clk);
        chk("R9", "reset valid", 32'(out_valid), 0);
        chk("R9", "reset packet", out_packet, 0);
        chk("R9", "reset plan", 32'(out_cs_plan), 0);
        chk("R9", "reset polarity", 32'(out_polarity), 0);
        rst = 0;
        step(1, 0, 100);
        step(1, 1, -100);
        step(1, 2, 8191);
        step(1, 3, 8192);
        step(1, 2, -32768);
        step(1, 3, -8191);
        step(1, 0, 32767);
        step(1, 1, 0);
        step(0, 3, 16'h8001);
        step(0, 0, 1234);
        step(1, 3, -1);
        step(1, 0, -9000);
        step(1, 3, 5);
        for (int i = 0; i < 300; i++) begin
            seed = nxt(seed);
            step(seed[31:30] != 2'b00, int'(seed[5:4]), int'(seed[27:12]));
        end
        step(0, 0, 0);
        step(0, 0, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule